// File: doc/BRIEF.md
# 32-Pin GPIO Data Bank Register Block

This block is one bank of general-purpose pins placed behind a small synchronous register bus. Software decides, per pin, whether the pin drives or listens, and it changes the driven levels without a read-modify-write. Besides a plain load of the whole output latch, two strobe registers let a write force selected latch bits high or low while every other bit keeps its value. This means two agents that share the bank cannot undo each other's updates.

The pad levels are brought into the clock domain through a two-flop synchronizer and appear in a read-only input register. That register shows the level on the pad even for pins the bank is driving, so software can read back what the pin really carries. The direction register uses an inverted sense: a 1 means the pin is an input. The pad output enable is the complement of the direction bit.

Bus accesses are single-cycle. A read is captured into a read-data register on the clock edge where `bus_valid` is high and `bus_we` is low, and the result appears after that edge. The asynchronous reset input is released to the internal logic two clock edges after it deasserts.

Top module: `gpio_bank`

## Requirements
- R1: While reset is asserted, and after it is released, the direction register is all ones, the output latch is all zeros, `pad_oe` and `pad_out` are zero, and `bus_rdata` is zero.
- R2: A write to word offset 0x00 loads the direction register. A direction bit of 1 marks an input and 0 marks an output, so `pad_oe` equals the inverted direction register after the write edge. A read of 0x00 returns the direction register.
- R3: A write to word offset 0x04 loads the output latch with the written word. `pad_out` equals the latch after the write edge, and a read of 0x04 returns the latch.
- R4: A write to offset 0x08 sets to 1 every latch bit whose written bit is 1, and leaves the latch bits under written 0s unchanged.
- R5: A write to offset 0x0C clears to 0 every latch bit whose written bit is 1, and leaves the latch bits under written 0s unchanged.
- R6: Reads of offsets 0x08 and 0x0C both return the current output latch.
- R7: A read of offset 0x10 returns the synchronized pad level of every pin, whatever its direction. Writes to 0x10 change no register.
- R8: A pad change made between two clock edges is returned by a read captured on the third edge that follows the change. Reads captured on the first and second edges still return the old level.
- R9: Word offsets 0x14 to 0x1C, and any address whose two low bits are not zero, read as zero and ignore writes.
- R10: `bus_rdata` changes only on an edge that captures a read. Writes and idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe for the current cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (5) | Byte address inside the bank |
| bus_wdata | input | PINS (32) | Write data |
| bus_rdata | output | PINS (32) | Registered read data |
| pad_in | input | PINS (32) | Pad levels, asynchronous to clk |
| pad_out | output | PINS (32) | Output latch driven to the pads |
| pad_oe | output | PINS (32) | Per-pin output enable, 1 = drive |

## Verification
The hardest behaviour to reach is the exact input latency: a pad change must stay invisible for two captured reads and become visible on the third. The bench changes `pad_in` on a falling edge and then issues three reads back to back with no idle cycle, so each read lands on a known edge. Readback through the input register on pins that are driven as outputs is reached by clearing the whole direction register first, and then driving pad levels that differ from the output latch.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned IDX_W = 3;
  localparam logic [IDX_W-1:0] IDX_DIR = 3'd0;
  localparam logic [IDX_W-1:0] IDX_LAT = 3'd1;
  localparam logic [IDX_W-1:0] IDX_SET = 3'd2;
  localparam logic [IDX_W-1:0] IDX_CLR = 3'd3;
  localparam logic [IDX_W-1:0] IDX_PIN = 3'd4;
  localparam int unsigned IDX_LAST = 4;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_ni,
  output logic srst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign srst_no = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      always_comb stage_d = async_i;
    end else begin : g_next
      always_comb stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_d;
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data,
  output logic [W-1:0]     dir_q,
  output logic [W-1:0]     lat_q
);
  logic [W-1:0] dir_d, lat_d;
  logic         dir_en, lat_en;
  logic         wr_set, wr_clr, wr_none;

  always_comb begin
    dir_d  = dir_q;
    lat_d  = lat_q;
    dir_en = 1'b0;
    lat_en = 1'b0;
    if (wr_en) begin
      case (wr_idx)
        IDX_DIR: begin dir_d = wr_data;          dir_en = 1'b1; end
        IDX_LAT: begin lat_d = wr_data;          lat_en = 1'b1; end
        IDX_SET: begin lat_d = lat_q | wr_data;  lat_en = 1'b1; end
        IDX_CLR: begin lat_d = lat_q & ~wr_data; lat_en = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '1;
      lat_q <= '0;
    end else begin
      if (dir_en) dir_q <= dir_d;
      if (lat_en) lat_q <= lat_d;
    end
  end

  assign wr_set  = wr_en && (wr_idx == IDX_SET);
  assign wr_clr  = wr_en && (wr_idx == IDX_CLR);
  assign wr_none = !wr_en || (wr_idx > IDX_CLR);

  assert_set_ones_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_set |=> ((lat_q & $past(wr_data)) == $past(wr_data)));
  assert_set_keep_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_set |=> ((lat_q & ~$past(wr_data)) == ($past(lat_q) & ~$past(wr_data))));
  assert_clr_zeros_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_clr |=> ((lat_q & $past(wr_data)) == '0));
  assert_clr_keep_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_clr |=> ((lat_q & ~$past(wr_data)) == ($past(lat_q) & ~$past(wr_data))));
  assert_no_write_hold_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_none |=> ($stable(dir_q) && $stable(lat_q)));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe
);
  localparam int WORD_W    = ADDR_W - 2;
  localparam int SYNC_DEEP = 2;

  logic              rst_ni;
  logic [WORD_W-1:0] word_idx;
  logic              mapped, wr_fire, rd_fire;
  logic [PINS-1:0]   dir_q, lat_q, pin_q;
  logic [PINS-1:0]   rd_d, rdata_q;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_ni(rst_n), .srst_no(rst_ni)
  );

  gpio_in_sync #(.W(PINS), .STAGES(SYNC_DEEP)) u_sync (
    .clk(clk), .rst_ni(rst_ni), .async_i(pad_in), .sync_o(pin_q)
  );

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign mapped   = (bus_addr[1:0] == 2'b00) && (word_idx <= WORD_W'(IDX_LAST));
  assign wr_fire  = bus_valid && bus_we && mapped;
  assign rd_fire  = bus_valid && !bus_we;

  gpio_bank_regs #(.W(PINS)) u_regs (
    .clk(clk), .rst_ni(rst_ni), .wr_en(wr_fire),
    .wr_idx(word_idx[IDX_W-1:0]), .wr_data(bus_wdata),
    .dir_q(dir_q), .lat_q(lat_q)
  );

  always_comb begin
    rd_d = '0;
    if (mapped) begin
      case (word_idx[IDX_W-1:0])
        IDX_DIR:                   rd_d = dir_q;
        IDX_LAT, IDX_SET, IDX_CLR: rd_d = lat_q;
        IDX_PIN:                   rd_d = pin_q;
        default:                   rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_fire) rdata_q <= rd_d;
  end

  assign bus_rdata = rdata_q;
  assign pad_out   = lat_q;
  assign pad_oe    = ~dir_q;

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    !rd_fire |=> $stable(bus_rdata));
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_fire && !mapped) |=> (bus_rdata == '0));
  assert_pin_read_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_fire && mapped && word_idx == WORD_W'(IDX_PIN)) |=> (bus_rdata == $past(pin_q)));
endmodule

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_we;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, pad_in, pad_out, pad_oe;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;
  logic [31:0] exp_dir, exp_lat, rv, oldpad;

  always #2 clk = ~clk;

  gpio_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_valid = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_wdata = '0; pad_in = '0;
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", pad_oe, 32'h0);
    chk("R1 out in reset", pad_out, 32'h0);
    chk("R1 rdata in reset", bus_rdata, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    exp_dir = '1; exp_lat = '0;
    rd(5'h00, rv); chk("R1 dir after reset", rv, exp_dir);
    rd(5'h04, rv); chk("R1 latch after reset", rv, exp_lat);

    // R2 direction patterns
    for (int i = 0; i < 8; i++) begin
      exp_dir = (32'h1357_9BDF * (i + 1)) ^ (32'hF0F0_0000 >> i);
      wr(5'h00, exp_dir);
      chk("R2 pad_oe", pad_oe, ~exp_dir);
      rd(5'h00, rv); chk("R2 dir readback", rv, exp_dir);
    end

    // R3 direct load
    for (int i = 0; i < 8; i++) begin
      exp_lat = (32'h2468_ACE1 * (i + 3)) ^ {i[7:0], 24'h5A5A5A};
      wr(5'h04, exp_lat);
      chk("R3 pad_out", pad_out, exp_lat);
      rd(5'h04, rv); chk("R3 latch readback", rv, exp_lat);
    end

    // R4 walking set
    wr(5'h04, 32'h0); exp_lat = '0;
    for (int b = 0; b < 32; b++) begin
      wr(5'h08, 32'h1 << b);
      exp_lat = exp_lat | (32'h1 << b);
      chk("R4 walking set", pad_out, exp_lat);
    end
    wr(5'h04, 32'h00FF_00F0); wr(5'h08, 32'h0F0F_0F0F);
    chk("R4 pattern set", pad_out, 32'h0FFF_0FFF);

    // R5 walking clear
    wr(5'h04, 32'hFFFF_FFFF); exp_lat = '1;
    for (int b = 31; b >= 0; b--) begin
      wr(5'h0C, 32'h1 << b);
      exp_lat = exp_lat & ~(32'h1 << b);
      chk("R5 walking clear", pad_out, exp_lat);
    end
    wr(5'h04, 32'hF0F0_FFFF); wr(5'h0C, 32'h3C3C_00FF);
    chk("R5 pattern clear", pad_out, 32'hC0C0_FF00);

    // R6 readback through strobe offsets
    rd(5'h08, rv); chk("R6 read set offset", rv, 32'hC0C0_FF00);
    rd(5'h0C, rv); chk("R6 read clear offset", rv, 32'hC0C0_FF00);

    // R7 pad level with all pins driven
    wr(5'h00, 32'h0);
    pad_in = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rd(5'h10, rv); chk("R7 pad on outputs", rv, 32'h1234_5678);
    wr(5'h10, 32'hFFFF_FFFF);
    chk("R7 write to input offset out", pad_out, 32'hC0C0_FF00);
    rd(5'h00, rv); chk("R7 write to input offset dir", rv, 32'h0);
    rd(5'h10, rv); chk("R7 input unchanged", rv, 32'h1234_5678);

    // R8 latency: old, old, new
    oldpad = pad_in;
    pad_in = 32'hA5C3_0FF1;
    rd(5'h10, rv); chk("R8 first edge old", rv, oldpad);
    rd(5'h10, rv); chk("R8 second edge old", rv, oldpad);
    rd(5'h10, rv); chk("R8 third edge new", rv, 32'hA5C3_0FF1);

    // R9 unmapped and misaligned
    wr(5'h00, 32'h0000_FFFF);
    for (int k = 5; k < 8; k++) begin
      wr(5'(k * 4), 32'hDEAD_BEEF);
      rd(5'(k * 4), rv); chk("R9 unmapped reads zero", rv, 32'h0);
    end
    for (int m = 1; m < 4; m++) begin
      wr(5'(m), 32'hFFFF_0000);
      wr(5'(m + 4), 32'h1111_1111);
      rd(5'(m), rv); chk("R9 misaligned reads zero", rv, 32'h0);
    end
    chk("R9 dir untouched", pad_oe, 32'hFFFF_0000);
    chk("R9 latch untouched", pad_out, 32'hC0C0_FF00);

    // R10 rdata holds across writes and idle
    rd(5'h04, rv);
    wr(5'h00, 32'h1234_0000);
    wr(5'h04, 32'h0);
    repeat (2) @(negedge clk);
    chk("R10 rdata held", bus_rdata, 32'hC0C0_FF00);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule